// File: doc/BRIEF.md
# Monochrome Dot-Matrix Frame Memory Host Port

This block sits between a host processor and the frame store of a monochrome dot-matrix display controller. The host talks to it over an 8-bit parallel bus with three strobes: an active-low chip enable, a write-select (low for a write, high for a read), and a data/command select. Command bytes set a small set of mode registers and the address counters. Data bytes move pixel words into and out of a 120-column by 64-row bitmap, where one bit is one dot: a 1 lights the dot and a 0 leaves it dark.

All bus strobes are sampled into the system clock domain. A write takes effect when chip enable returns high. During a read, the block drives the bus for as long as chip enable is held low. At run time the pixel word can be 8 dots or 6 dots wide, and the same column counter indexes words of either width. After every data transfer the address moves on by one step. The axis and the direction of that step come from a mode register. A second, read-only row port lets a scan engine fetch whole rows, offset by a programmable start line.

Top module: `disp_host_if`

## Requirements
- R1: A synchronous active-high `rst` puts the block in this state: row 0, column 0, 8-dot words, display off, column axis counting up, start line 0, bus not driven. The status byte then reads 0x41.
- R2: A write happens when `ce_n` rises while `wr_n` is low and `di` is high. The bus byte is then stored in the current row at the current column word. Bus bit k goes to dot (column × word width + k), and that dot is bit index (column × word width + k) of `scan_bits`.
- R3: While `ce_n` is low with `wr_n` high, `bus_oe` is 1 and `bus_out` carries the read value. Within two clocks after `ce_n` goes high, `bus_oe` is 0 and `bus_out` is 0.
- R4: A data read (`di` high) returns the read buffer. When `ce_n` rises at the end of that read, the buffer is reloaded from the word at the current address and the address then advances. The first read after an address change therefore returns stale data. The buffer reads 0 after reset.
- R5: Command 0x00 selects 6-dot words (20 columns per row) and 0x01 selects 8-dot words (15 columns). In 6-dot mode, bus bits 7:6 are not stored on writes and read back as 0. Changing to a width whose column count does not include the current column resets the column to 0.
- R6: With the column axis selected, each data transfer steps the column by one word. Counting up wraps from the last column to 0, and counting down wraps from 0 to the last column.
- R7: Command 0b0000_01ad sets the step axis (a=1: row, a=0: column) and the direction (d=1: up, d=0: down). Row steps wrap modulo 64, so counting down from row 0 gives row 63.
- R8: Command 0b10rr_rrrr sets the row. Command 0b001c_cccc sets the column; a value outside the current column count sets 0 instead. Bytes 0x08–0x1F and 0xC0–0xFF change nothing.
- R9: Command 0x03 turns the display on and 0x02 turns it off; the state appears on `disp_on`. A command read (`di` low) returns the status byte: bit 6 = 8-dot mode, bit 5 = display on, bit 1 = row axis, bit 0 = count up, all other bits 0.
- R10: Command 0b01ss_ssss sets the start line s. One clock after `scan_row` is applied, `scan_bits` holds stored row (`scan_row` + s) mod 64.
- R11: While `stby_n` is low, command and data bus cycles change no register, no stored dot and no address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| stby_n | input | 1 | Standby, active low; bus cycles are ignored while low |
| ce_n | input | 1 | Bus chip enable, active low |
| wr_n | input | 1 | Write-select: low for a write, high for a read |
| di | input | 1 | High: data byte; low: command or status byte |
| bus_in | input | 8 | Byte from the host |
| bus_out | output | 8 | Byte to the host, 0 when not driven |
| bus_oe | output | 1 | Bus output enable |
| scan_row | input | 6 | Row requested by the scan engine |
| scan_bits | output | 120 | Dots of the stored row that `scan_row` selects after the start-line offset |
| disp_on | output | 1 | Display enable state |

## Verification
The bench aims at the points where the 6-dot and 8-dot packings meet. It writes the last 6-dot column, where a packing error would spill into or lose the top dots, and it switches width while the column is out of range, which a design without the clamp would leave at column 19. It checks that the first read after an address change is stale and that the next one is correct; a design without the read pipeline would return correct data one read too early. It also covers column wrap in both directions, row steps down through zero, a start-line sum that passes row 63, and bus cycles made in standby, any of which a faulty design would let change state.

// File: rtl/disp_pkg.sv
package disp_pkg;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_WLEN,
    CMD_DISP,
    CMD_MODE,
    CMD_COL,
    CMD_SCROLL,
    CMD_ROW
  } cmd_e;

  // Opcode classes are told apart by their leading bits.
  function automatic cmd_e cmd_decode(logic [7:0] b);
    cmd_e k;
    casez (b)
      8'b0000_000?: k = CMD_WLEN;
      8'b0000_001?: k = CMD_DISP;
      8'b0000_01??: k = CMD_MODE;
      8'b001?_????: k = CMD_COL;
      8'b01??_????: k = CMD_SCROLL;
      8'b10??_????: k = CMD_ROW;
      default:      k = CMD_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/disp_bus_sync.sv
module disp_bus_sync #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          stby_n,
  input  logic          ce_n,
  input  logic          wr_n,
  input  logic          di,
  input  logic [DW-1:0] bus_in,
  output logic          wr_stb,
  output logic          rd_stb,
  output logic          sel_data,
  output logic [DW-1:0] byte_q,
  output logic          reading,
  output logic          live_di
);

  logic          ce_q, ce_d, wr_q, di_q;
  logic [DW-1:0] d_q;
  logic          ce_rise;

  assign ce_rise = ce_q & ~ce_d;
  assign reading = ~ce_q & wr_q;
  assign live_di = di_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ce_q     <= 1'b1;
      ce_d     <= 1'b1;
      wr_q     <= 1'b1;
      di_q     <= 1'b0;
      d_q      <= '0;
      wr_stb   <= 1'b0;
      rd_stb   <= 1'b0;
      sel_data <= 1'b0;
      byte_q   <= '0;
    end else begin
      ce_q     <= ce_n;
      ce_d     <= ce_q;
      wr_q     <= wr_n;
      di_q     <= di;
      d_q      <= bus_in;
      wr_stb   <= ce_rise & ~wr_q & stby_n;
      rd_stb   <= ce_rise & wr_q & stby_n;
      sel_data <= di_q;
      byte_q   <= d_q;
    end
  end

endmodule

// File: rtl/disp_addr_ctrl.sv
module disp_addr_ctrl
  import disp_pkg::*;
#(
  parameter int COLS   = 120,
  parameter int ROWS   = 64,
  parameter int DW     = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 6
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_stb,
  input  logic                        rd_stb,
  input  logic                        sel_data,
  input  logic [DW-1:0]               byte_q,
  output logic [$clog2(ROWS)-1:0]     row,
  output logic [$clog2(ROWS)-1:0]     scroll,
  output logic [$clog2(COLS/NARROW)-1:0] col,
  output logic                        wide,
  output logic                        disp_on,
  output logic                        axis_row,
  output logic                        dir_up,
  output logic                        ram_we,
  output logic [COLS-1:0]             ram_mask,
  output logic [COLS-1:0]             ram_wdata,
  output logic [$clog2(COLS)-1:0]     bit_base
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int NC_W  = COLS / WIDE;
  localparam int NC_N  = COLS / NARROW;
  localparam int COL_W = $clog2(NC_N);
  localparam int BIT_W = $clog2(COLS);
  localparam logic [COLS-1:0] LANE_W = COLS'((1 << WIDE) - 1);
  localparam logic [COLS-1:0] LANE_N = COLS'((1 << NARROW) - 1);

  logic [COL_W-1:0] last;
  logic             step;

  assign last     = wide ? COL_W'(NC_W - 1) : COL_W'(NC_N - 1);
  assign step     = (wr_stb | rd_stb) & sel_data;
  assign ram_we   = wr_stb & sel_data;
  assign bit_base = wide ? BIT_W'(col * WIDE) : BIT_W'(col * NARROW);
  assign ram_mask  = (wide ? LANE_W : LANE_N) << bit_base;
  assign ram_wdata = COLS'(byte_q) << bit_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      row      <= '0;
      col      <= '0;
      scroll   <= '0;
      wide     <= 1'b1;
      disp_on  <= 1'b0;
      axis_row <= 1'b0;
      dir_up   <= 1'b1;
    end else if (wr_stb && !sel_data) begin
      case (cmd_decode(byte_q[7:0]))
        CMD_WLEN: begin
          wide <= byte_q[0];
          if (byte_q[0] && col > COL_W'(NC_W - 1)) col <= '0;
        end
        CMD_DISP:   disp_on <= byte_q[0];
        CMD_MODE: begin
          axis_row <= byte_q[1];
          dir_up   <= byte_q[0];
        end
        CMD_COL:    col    <= (byte_q[COL_W-1:0] > last) ? '0 : byte_q[COL_W-1:0];
        CMD_SCROLL: scroll <= byte_q[ROW_W-1:0];
        CMD_ROW:    row    <= byte_q[ROW_W-1:0];
        default: ;
      endcase
    end else if (step) begin
      if (axis_row) begin
        row <= dir_up ? row + 1'b1 : row - 1'b1;
      end else if (dir_up) begin
        col <= (col == last) ? '0 : col + 1'b1;
      end else begin
        col <= (col == '0) ? last : col - 1'b1;
      end
    end
  end

endmodule

// File: rtl/disp_frame_ram.sv
module disp_frame_ram #(
  parameter int COLS = 120,
  parameter int ROWS = 64
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [$clog2(ROWS)-1:0] wrow,
  input  logic [COLS-1:0]         mask,
  input  logic [COLS-1:0]         wdata,
  input  logic [$clog2(ROWS)-1:0] hrow,
  output logic [COLS-1:0]         hq,
  input  logic [$clog2(ROWS)-1:0] srow,
  output logic [COLS-1:0]         sq
);

  logic [COLS-1:0] mem [ROWS] = '{default: '0};

  initial begin
    hq = '0;
    sq = '0;
  end

  always @(posedge clk) begin
    if (we) begin
      for (int b = 0; b < COLS; b++) begin
        if (mask[b]) mem[wrow][b] <= wdata[b];
      end
    end
    hq <= mem[hrow];
    sq <= mem[srow];
  end

endmodule

// File: rtl/disp_host_if.sv
module disp_host_if
  import disp_pkg::*;
#(
  parameter int COLS   = 120,
  parameter int ROWS   = 64,
  parameter int DW     = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 6
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stby_n,
  input  logic                    ce_n,
  input  logic                    wr_n,
  input  logic                    di,
  input  logic [DW-1:0]           bus_in,
  output logic [DW-1:0]           bus_out,
  output logic                    bus_oe,
  input  logic [$clog2(ROWS)-1:0] scan_row,
  output logic [COLS-1:0]         scan_bits,
  output logic                    disp_on
);

  localparam int ROW_W = $clog2(ROWS);
  localparam int COL_W = $clog2(COLS / NARROW);
  localparam int BIT_W = $clog2(COLS);
  localparam logic [DW-1:0] MASK_W = DW'((1 << WIDE) - 1);
  localparam logic [DW-1:0] MASK_N = DW'((1 << NARROW) - 1);

  logic             wr_stb, rd_stb, sel_data, reading, live_di;
  logic [DW-1:0]    byte_q;
  logic [ROW_W-1:0] row, scroll;
  logic [COL_W-1:0] col;
  logic             wide, axis_row, dir_up, ram_we, rd_load;
  logic [COLS-1:0]  ram_mask, ram_wdata, host_q;
  logic [BIT_W-1:0] bit_base;
  logic [DW-1:0]    word, rdbuf, status;
  logic [ROW_W-1:0] scan_phys;

  disp_bus_sync #(.DW(DW)) u_sync (
    .clk(clk), .rst(rst), .stby_n(stby_n), .ce_n(ce_n), .wr_n(wr_n), .di(di),
    .bus_in(bus_in), .wr_stb(wr_stb), .rd_stb(rd_stb), .sel_data(sel_data),
    .byte_q(byte_q), .reading(reading), .live_di(live_di)
  );

  disp_addr_ctrl #(
    .COLS(COLS), .ROWS(ROWS), .DW(DW), .WIDE(WIDE), .NARROW(NARROW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .rd_stb(rd_stb), .sel_data(sel_data),
    .byte_q(byte_q), .row(row), .scroll(scroll), .col(col), .wide(wide),
    .disp_on(disp_on), .axis_row(axis_row), .dir_up(dir_up), .ram_we(ram_we),
    .ram_mask(ram_mask), .ram_wdata(ram_wdata), .bit_base(bit_base)
  );

  assign scan_phys = scan_row + scroll;

  disp_frame_ram #(.COLS(COLS), .ROWS(ROWS)) u_ram (
    .clk(clk), .we(ram_we), .wrow(row), .mask(ram_mask), .wdata(ram_wdata),
    .hrow(row), .hq(host_q), .srow(scan_phys), .sq(scan_bits)
  );

  assign rd_load = rd_stb & sel_data;
  assign word    = DW'(host_q >> bit_base) & (wide ? MASK_W : MASK_N);
  assign status  = DW'({1'b0, wide, disp_on, 3'b000, axis_row, dir_up});

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_oe  <= 1'b0;
      bus_out <= '0;
      rdbuf   <= '0;
    end else begin
      bus_oe  <= reading;
      bus_out <= reading ? (live_di ? rdbuf : status) : '0;
      if (rd_load) rdbuf <= word;
    end
  end

endmodule

// File: rtl/disp_host_if_chk.sv
module disp_host_if_chk #(
  parameter int COLS   = 120,
  parameter int ROWS   = 64,
  parameter int DW     = 8,
  parameter int WIDE   = 8,
  parameter int NARROW = 6
) (
  input logic                             clk,
  input logic                             rst,
  input logic                             ce_n,
  input logic                             wr_n,
  input logic                             stby_n,
  input logic                             bus_oe,
  input logic [DW-1:0]                    bus_out,
  input logic                             ram_we,
  input logic                             rd_load,
  input logic                             wide,
  input logic [$clog2(COLS/NARROW)-1:0]   col,
  input logic [$clog2(ROWS)-1:0]          row,
  input logic                             axis_row,
  input logic                             dir_up,
  input logic [DW-1:0]                    rdbuf
);

  localparam int NC_W  = COLS / WIDE;
  localparam int NC_N  = COLS / NARROW;
  localparam int COL_W = $clog2(NC_N);
  localparam int ROW_W = $clog2(ROWS);

  AST_RESET_STATE: assert property (@(posedge clk)
    rst |=> (!bus_oe && col == '0 && row == '0 && wide)); // R1

  AST_OE_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
    bus_oe |-> ($past(ce_n, 2) == 1'b0 && $past(wr_n, 2) == 1'b1)); // R3

  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (rst)
    !bus_oe |-> bus_out == '0); // R3

  AST_NARROW_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_load && !wide) |=> rdbuf[DW-1:NARROW] == '0); // R5

  AST_COL_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    wide ? (col < COL_W'(NC_W)) : (col < COL_W'(NC_N))); // R6

  AST_COL_STEP_UP: assert property (@(posedge clk) disable iff (rst)
    (ram_we && !axis_row && dir_up && wide && col != COL_W'(NC_W - 1))
      |=> col == $past(col) + 1'b1); // R6

  AST_ROW_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
    (ram_we && axis_row && !dir_up) |=> row == ROW_W'($past(row) - 1'b1)); // R7

  AST_STBY_BLOCKS: assert property (@(posedge clk) disable iff (rst)
    (ram_we || rd_load) |-> $past(stby_n)); // R11

endmodule

bind disp_host_if disp_host_if_chk #(
  .COLS(COLS), .ROWS(ROWS), .DW(DW), .WIDE(WIDE), .NARROW(NARROW)
) u_chk (
  .clk(clk), .rst(rst), .ce_n(ce_n), .wr_n(wr_n), .stby_n(stby_n),
  .bus_oe(bus_oe), .bus_out(bus_out), .ram_we(ram_we), .rd_load(rd_load),
  .wide(wide), .col(col), .row(row), .axis_row(axis_row), .dir_up(dir_up),
  .rdbuf(rdbuf)
);

// File: tb/disp_host_if_tb.sv
`timescale 1ns/1ps
module disp_host_if_tb;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         stby_n = 1'b1;
  logic         ce_n = 1'b1;
  logic         wr_n = 1'b1;
  logic         di = 1'b0;
  logic [7:0]   bus_in = '0;
  logic [7:0]   bus_out;
  logic         bus_oe;
  logic [5:0]   scan_row = '0;
  logic [119:0] scan_bits;
  logic         disp_on;

  int n_vec = 0;
  int n_bad = 0;
  logic done = 1'b0;

  string        tag_q[$];
  logic [119:0] exp_q[$];
  logic [119:0] obs_q[$];

  always #2 clk = ~clk;

  disp_host_if u_dut (
    .clk(clk), .rst(rst), .stby_n(stby_n), .ce_n(ce_n), .wr_n(wr_n), .di(di),
    .bus_in(bus_in), .bus_out(bus_out), .bus_oe(bus_oe), .scan_row(scan_row),
    .scan_bits(scan_bits), .disp_on(disp_on)
  );

  // Monitor: drains observations against expectations
  always @(posedge clk) begin
    while (obs_q.size() > 0) begin
      string        t;
      logic [119:0] e, a;
      t = tag_q.pop_front();
      e = exp_q.pop_front();
      a = obs_q.pop_front();
      n_vec++;
      if (a !== e) begin
        n_bad++;
        $display("FAIL %s: actual %h expected %h", t, a, e);
      end
    end
  end

  task automatic check(string t, logic [119:0] e, logic [119:0] a);
    tag_q.push_back(t);
    exp_q.push_back(e);
    obs_q.push_back(a);
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_wr(logic dsel, logic [7:0] b);
    @(negedge clk);
    wr_n = 1'b0; di = dsel; bus_in = b; ce_n = 1'b0;
    tick(3);
    ce_n = 1'b1;
    tick(4);
    wr_n = 1'b1;
  endtask

  task automatic cmd(logic [7:0] b);  bus_wr(1'b0, b); endtask
  task automatic wdat(logic [7:0] b); bus_wr(1'b1, b); endtask

  task automatic rd_chk(logic dsel, logic [7:0] e, string t, logic cmp);
    logic [7:0] v;
    @(negedge clk);
    wr_n = 1'b1; di = dsel; ce_n = 1'b0;
    tick(4);
    v = bus_out;
    check("R3 bus driven during read", 120'd1, 120'(bus_oe));
    ce_n = 1'b1;
    tick(4);
    check("R3 bus released", 120'd0, 120'({bus_oe, bus_out}));
    if (cmp) check(t, 120'(e), 120'(v));
  endtask

  task automatic scan_chk(logic [5:0] r, logic [119:0] e, string t);
    @(negedge clk);
    scan_row = r;
    tick(2);
    check(t, e, scan_bits);
  endtask

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_bad++;
      $display("FAIL R1 watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    tick(4);
    rst = 1'b0;
    tick(2);
    // R1 reset state
    check("R1 bus idle after reset", 120'd0, 120'(bus_oe));
    rd_chk(1'b0, 8'h41, "R1 status after reset", 1'b1);
    scan_chk(6'd0, 120'd0, "R1 cleared row 0");

    // R2 writes, R6 column step
    wdat(8'hA5);
    scan_chk(6'd0, 120'hA5, "R2 first word stored");
    wdat(8'h3C);
    scan_chk(6'd0, 120'h3CA5, "R6 second word at next column");

    // R4 pipelined reads
    cmd(8'h20);
    rd_chk(1'b1, 8'h00, "R4 dummy read after reset", 1'b1);
    rd_chk(1'b1, 8'hA5, "R4 column 0 read", 1'b1);
    rd_chk(1'b1, 8'h3C, "R4 column 1 read", 1'b1);

    // R6 wrap at last 8-dot column
    cmd(8'h2E);
    wdat(8'hFF);
    wdat(8'h11);
    scan_chk(6'd0, (120'hFF << 112) | 120'h3C11, "R6 wrap from column 14 to 0");

    // R7 row axis, counting down
    cmd(8'h06);
    cmd(8'h85);
    cmd(8'h22);
    wdat(8'h81);
    wdat(8'h42);
    scan_chk(6'd5, 120'h81 << 16, "R7 row 5 written");
    scan_chk(6'd4, 120'h42 << 16, "R7 row stepped down to 4");
    rd_chk(1'b0, 8'h42, "R9 status row axis down", 1'b1);
    cmd(8'h80);
    wdat(8'h07);
    wdat(8'h09);
    scan_chk(6'd63, 120'h09 << 16, "R7 row 0 down wraps to 63");

    // R5 6-dot words
    cmd(8'h00);
    cmd(8'h05);
    cmd(8'h8A);
    cmd(8'h33);
    wdat(8'hFF);
    wdat(8'hEA);
    scan_chk(6'd10, (120'h3F << 114) | 120'h2A, "R5 narrow packing and wrap at 19");
    rd_chk(1'b0, 8'h01, "R5 status narrow mode", 1'b1);
    cmd(8'h20);
    rd_chk(1'b1, 8'h00, "R4 dummy", 1'b0);
    rd_chk(1'b1, 8'h2A, "R5 narrow read upper bits zero", 1'b1);
    cmd(8'h39);
    wdat(8'h15);
    scan_chk(6'd10, (120'h3F << 114) | 120'h15, "R8 column out of range goes to 0");
    cmd(8'h33);
    cmd(8'h01);
    wdat(8'h77);
    scan_chk(6'd10, (120'h3F << 114) | 120'h77, "R5 width change clamps column");

    // R8 reserved opcodes
    cmd(8'hC5);
    cmd(8'h0B);
    rd_chk(1'b0, 8'h41, "R8 reserved opcodes ignored", 1'b1);

    // R9 display on/off
    cmd(8'h03);
    rd_chk(1'b0, 8'h61, "R9 status display on", 1'b1);
    check("R9 disp_on high", 120'd1, 120'(disp_on));
    cmd(8'h02);
    check("R9 disp_on low", 120'd0, 120'(disp_on));

    // R10 start line offset
    cmd(8'h45);
    scan_chk(6'd0, 120'h81 << 16, "R10 offset 5 selects row 5");
    cmd(8'h7E);
    scan_chk(6'd12, (120'h3F << 114) | 120'h77, "R10 offset wraps past 63");
    cmd(8'h40);

    // R11 standby
    @(negedge clk) stby_n = 1'b0;
    cmd(8'h03);
    wdat(8'hFF);
    @(negedge clk) stby_n = 1'b1;
    rd_chk(1'b0, 8'h41, "R11 command ignored in standby", 1'b1);
    scan_chk(6'd10, (120'h3F << 114) | 120'h77, "R11 data ignored in standby");
    wdat(8'h5A);
    scan_chk(6'd10, (120'h3F << 114) | 120'h5A77, "R11 address unchanged in standby");

    // R1 reset mid-run
    cmd(8'h03);
    cmd(8'h8A);
    @(negedge clk) rst = 1'b1;
    tick(2);
    check("R1 bus idle in reset", 120'd0, 120'(bus_oe));
    rst = 1'b0;
    tick(1);
    check("R1 display off after reset", 120'd0, 120'(disp_on));
    rd_chk(1'b0, 8'h41, "R1 status after second reset", 1'b1);
    rd_chk(1'b1, 8'h00, "R1 dummy", 1'b0);
    rd_chk(1'b1, 8'h11, "R1 address back at row 0 column 0", 1'b1);

    tick(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule